// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a 32-bit logical address issued by a DMA engine into a physical address. It reads one entry from a flat, single-level table that sits in system memory. Software places the table and sets two configuration registers. The base register gives the table's byte address, and the top bit of that value is ignored. The limit register gives the table's length in bytes.

Each translation request passes a range check on the page index. A request that passes triggers one 32-bit read of the entry's frame word through a request/response memory port. The 4 KiB frame number from that word is then joined with the untouched page offset. A request that fails the range check, or whose read returns an error, finishes with a fault and a zero address. No memory is read for a request that fails the range check.

Each table entry is 8 bytes long. The frame word is at the entry's start and the word after it is unused. The block handles one request at a time. It captures the configuration when it accepts a request, so a register write made during a walk applies only to later requests.

Top module: `dma_xlate`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `done`, `fault`, `mem_rd_valid` and `paddr` are 0. Base and limit are both 0, so the first request faults.
- R2: On a successful translation, `paddr[11:0]` equals `req_laddr[11:0]`.
- R3: The entry read address is the base register with bit 31 forced to 0, plus (`req_laddr >> 12`) × 8, computed modulo 2^32.
- R4: On success, `paddr[31:12]` equals bits 31..12 of the fetched frame word. Bits 11..0 of that word are discarded.
- R5: A page index is in range only when it is strictly less than floor(limit / 8). An index equal to that value, or above it, is out of range. Limit bits 2..0 therefore never add an entry.
- R6: An out-of-range request issues no memory read. It ends with `done` = 1, `fault` = 1 and `paddr` = 0.
- R7: A read answered with `mem_rsp_err` = 1 ends with `fault` = 1 and `paddr` = 0.
- R8: Once a request is accepted, `req_ready` stays 0 until the walk has finished. `done` is a one-cycle pulse. After a read, `done` rises in the cycle that follows the one in which `mem_rsp_valid` was high.
- R9: While `mem_rd_ready` is 0, `mem_rd_valid` stays high and `mem_rd_addr` does not change.
- R10: Base and limit are sampled when a request is accepted. A write made during a walk affects only requests accepted after it.
- R11: `cfg_we` with `cfg_sel` = 0 writes the base register. `cfg_we` with `cfg_sel` = 1 writes the limit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 selects base, 1 selects limit |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_laddr | input | 32 | Logical address to translate |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry's frame word |
| mem_rsp_valid | input | 1 | Read response valid, one cycle |
| mem_rsp_data | input | 32 | Frame word returned |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | Translation finished, one-cycle pulse |
| fault | output | 1 | Translation failed, valid with done |
| paddr | output | 32 | Physical address, valid with done |

## Verification
The assertions check on every cycle the properties that relate handshakes to one another:
- a busy block never shows ready;
- done is a single pulse that lands one cycle after a response;
- a stalled read keeps its valid and address;
- no read is ever issued for an index that failed the range check;
- an errored response turns into a fault;
- a successful result keeps the page offset.

Only the directed scenarios can show that the arithmetic is right. They check the entry address with base bit 31 set, frame masking, the limit boundary when the limit is and is not a multiple of 8, and that a configuration change made mid-walk stays invisible until the next request.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_t;

  localparam logic CFG_SEL_BASE  = 1'b0;
  localparam logic CFG_SEL_LIMIT = 1'b1;
  localparam int   CFG_REGS      = 2;

endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import dma_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q
);

  logic [AW-1:0] regs_q [CFG_REGS];

  for (genvar g = 0; g < CFG_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (cfg_we && (int'(cfg_sel) == g)) begin
        regs_q[g] <= cfg_wdata;
      end
    end
  end

  assign base_q  = regs_q[int'(CFG_SEL_BASE)];
  assign limit_q = regs_q[int'(CFG_SEL_LIMIT)];

endmodule

// File: rtl/xlate_index_check.sv
module xlate_index_check #(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] laddr_q,
  output logic [AW-1:0] entry_addr_q,
  output logic          in_range_q
);

  localparam int IDX_W = AW - PAGE_BITS;

  logic [AW-1:0] page_idx;
  logic [AW-1:0] n_entries;
  logic [AW-1:0] base_masked;
  logic [AW-1:0] entry_addr;
  logic          in_range;

  always_comb begin
    page_idx    = {{PAGE_BITS{1'b0}}, laddr[AW-1:PAGE_BITS]};
    n_entries   = limit >> ENTRY_SHIFT;
    base_masked = {1'b0, base[AW-2:0]};
    entry_addr  = base_masked + (page_idx << ENTRY_SHIFT);
    in_range    = (page_idx < n_entries);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      laddr_q      <= '0;
      entry_addr_q <= '0;
      in_range_q   <= 1'b0;
    end else if (load) begin
      laddr_q      <= laddr;
      entry_addr_q <= entry_addr;
      in_range_q   <= in_range;
    end
  end

  // The captured index fits in IDX_W bits.
  assert_idx_width_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (laddr_q[AW-1:PAGE_BITS] == $past(laddr[AW-1:AW-IDX_W])));

endmodule

// File: rtl/xlate_walk_fsm.sv
module xlate_walk_fsm
  import dma_xlate_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          load,
  input  logic [AW-1:0] laddr_q,
  input  logic [AW-1:0] entry_addr_q,
  input  logic          in_range_q,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] paddr
);

  walk_state_t   state_q;
  logic          ready_q;
  logic          rd_valid_q;
  logic [AW-1:0] rd_addr_q;
  logic          done_q;
  logic          fault_q;
  logic [AW-1:0] paddr_q;

  assign load = req_valid && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ready_q    <= 1'b1;
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      paddr_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          done_q <= 1'b0;
          if (load) begin
            ready_q <= 1'b0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (in_range_q) begin
            rd_valid_q <= 1'b1;
            rd_addr_q  <= entry_addr_q;
            state_q    <= ST_ISSUE;
          end else begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_ISSUE: begin
          if (mem_rd_ready) begin
            rd_valid_q <= 1'b0;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            done_q  <= 1'b1;
            state_q <= ST_DONE;
            if (mem_rsp_err) begin
              fault_q <= 1'b1;
              paddr_q <= '0;
            end else begin
              fault_q <= 1'b0;
              paddr_q <= {mem_rsp_data[AW-1:PAGE_BITS], laddr_q[PAGE_BITS-1:0]};
            end
          end
        end
        ST_DONE: begin
          done_q  <= 1'b0;
          ready_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
          ready_q <= 1'b1;
        end
      endcase
    end
  end

  assign req_ready    = ready_q;
  assign mem_rd_valid = rd_valid_q;
  assign mem_rd_addr  = rd_addr_q;
  assign done         = done_q;
  assign fault        = fault_q;
  assign paddr        = paddr_q;

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_timing_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && mem_rsp_valid) |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_err_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && mem_rsp_valid && mem_rsp_err) |=> (done && fault && paddr == '0));

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_laddr,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] paddr
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] limit_q;
  logic          load;
  logic [AW-1:0] laddr_q;
  logic [AW-1:0] entry_addr_q;
  logic          in_range_q;

  xlate_cfg_regs #(.AW(AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .limit_q   (limit_q)
  );

  xlate_index_check #(
    .AW          (AW),
    .PAGE_BITS   (PAGE_BITS),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_idx (
    .clk          (clk),
    .rst          (rst),
    .load         (load),
    .laddr        (req_laddr),
    .base         (base_q),
    .limit        (limit_q),
    .laddr_q      (laddr_q),
    .entry_addr_q (entry_addr_q),
    .in_range_q   (in_range_q)
  );

  xlate_walk_fsm #(
    .AW        (AW),
    .PAGE_BITS (PAGE_BITS)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .load          (load),
    .laddr_q       (laddr_q),
    .entry_addr_q  (entry_addr_q),
    .in_range_q    (in_range_q),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
  );

  assert_no_oob_read_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> in_range_q);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (paddr[PAGE_BITS-1:0] == laddr_q[PAGE_BITS-1:0]));

endmodule

// File: tb/dma_xlate_bench.sv
module dma_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done;
  logic        fault;
  logic [31:0] paddr;

  int checks = 0;
  int fails  = 0;

  int          lat = 1;
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  int          nreads = 0;
  logic [31:0] last_rd_addr = '0;
  int          cyc = 0;
  int          rsp_cyc = 0;

  always #5 clk = ~clk;

  dma_xlate u_dma_xlate (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
  );

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return (a * 32'h9E37_79B1) | 32'h0000_0F01;
  endfunction

  // Memory model: answers a read lat cycles after it is accepted.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      cnt <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= frame_of(pend_addr);
        mem_rsp_err   <= err_en && (pend_addr == err_addr);
        rsp_cyc       <= cyc + 1;
        cnt           <= 0;
      end else if (cnt > 1) begin
        cnt <= cnt - 1;
      end else if (mem_rd_valid && mem_rd_ready) begin
        pend_addr    <= mem_rd_addr;
        last_rd_addr <= mem_rd_addr;
        nreads       <= nreads + 1;
        cnt          <= lat;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_xlate(input logic [31:0] la, output logic [31:0] pa, output logic f,
                          output int reads, output logic [31:0] raddr, output int gap);
    int start_reads;
    int t;
    bit busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start_reads = nreads;
    req_laddr = la;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    t = 0;
    while (!done && t < 200) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      t++;
    end
    chk(t < 200, "R8 done timeout", 32'(t), 32'd200);
    pa = paddr; f = fault; reads = nreads - start_reads; raddr = last_rd_addr;
    gap = cyc - rsp_cyc;
    chk(busy_ok && !req_ready, "R8 ready low while busy", {31'd0, busy_ok}, 32'd1);
    @(negedge clk);
    chk(!done, "R8 done single pulse", {31'd0, done}, 32'd0);
  endtask

  // Runs one translation that must read exactly the entry at eaddr and succeed.
  task automatic expect_hit(input logic [31:0] la, input logic [31:0] eaddr, input string req);
    logic [31:0] pa, ra;
    logic f;
    int r, g;
    do_xlate(la, pa, f, r, ra, g);
    chk(r == 1 && ra == eaddr, {req, " entry address"}, ra, eaddr);
    chk(!f && pa == {frame_of(eaddr)[31:12], la[11:0]}, {req, " paddr"}, pa,
        {frame_of(eaddr)[31:12], la[11:0]});
    chk(g == 1, "R8 done one cycle after response", 32'(g), 32'd1);
  endtask

  // Runs one translation that must fault without reading memory.
  task automatic expect_oob(input logic [31:0] la, input string req);
    logic [31:0] pa, ra;
    logic f;
    int r, g;
    do_xlate(la, pa, f, r, ra, g);
    chk(r == 0, {req, " no read"}, 32'(r), 32'd0);
    chk(f && pa == 32'd0, {req, " fault zero"}, pa, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk(!done && !fault && !mem_rd_valid && paddr == 0, "R1 outputs idle", paddr, 32'd0);
    expect_oob(32'h0000_0000, "R1 zero limit");
  endtask

  task automatic t_basic;
    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'd64);
    lat = 1;
    expect_hit(32'h0000_3ABC, 32'h0001_0018, "R2 R3 R4 R11 basic");
    lat = 3;
    expect_hit(32'h0000_0FFF, 32'h0001_0000, "R2 R4 index0");
  endtask

  task automatic t_base_msb;
    cfg_write(1'b0, 32'h8002_0000);
    cfg_write(1'b1, 32'h0000_1000);
    lat = 2;
    expect_hit(32'h0005_1234, 32'h0002_0000 + 32'h51 * 8, "R3 base bit31 ignored");
  endtask

  task automatic t_bounds;
    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'd64);
    lat = 1;
    expect_hit(32'h0000_7000, 32'h0001_0038, "R5 last index");
    expect_oob(32'h0000_8000, "R5 R6 index equals entries");
    expect_oob(32'hFFFF_F000, "R6 far index");
    cfg_write(1'b1, 32'd63);
    expect_oob(32'h0000_7000, "R5 limit floored");
    expect_hit(32'h0000_6010, 32'h0001_0030, "R5 below floored limit");
  endtask

  task automatic t_error;
    logic [31:0] pa, ra;
    logic f;
    int r, g;
    cfg_write(1'b1, 32'd64);
    err_en = 1'b1;
    err_addr = 32'h0001_0010;
    do_xlate(32'h0000_2555, pa, f, r, ra, g);
    chk(r == 1 && f && pa == 0, "R7 read error faults", pa, 32'd0);
    err_en = 1'b0;
  endtask

  task automatic t_stall;
    logic [31:0] pa, ra;
    logic f;
    int r, g;
    mem_rd_ready = 1'b0;
    lat = 1;
    fork
      do_xlate(32'h0000_4321, pa, f, r, ra, g);
      begin
        logic [31:0] held;
        bit ok;
        ok = 1'b1;
        @(negedge clk);
        while (!mem_rd_valid) @(negedge clk);
        held = mem_rd_addr;
        repeat (3) begin
          @(negedge clk);
          if (!mem_rd_valid || mem_rd_addr != held) ok = 1'b0;
        end
        chk(ok, "R9 read held during stall", mem_rd_addr, held);
        mem_rd_ready = 1'b1;
      end
    join
    chk(!f && ra == 32'h0001_0020 && pa == {frame_of(32'h0001_0020)[31:12], 12'h321},
        "R9 result after stall", pa, {frame_of(32'h0001_0020)[31:12], 12'h321});
  endtask

  task automatic t_midwalk_cfg;
    logic [31:0] pa, ra;
    logic f;
    int r, g;
    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'd64);
    lat = 6;
    fork
      do_xlate(32'h0000_2000, pa, f, r, ra, g);
      begin
        repeat (2) @(negedge clk);
        cfg_write(1'b1, 32'd0);
        cfg_write(1'b0, 32'h0004_0000);
      end
    join
    chk(!f && ra == 32'h0001_0010, "R10 walk uses old config", ra, 32'h0001_0010);
    lat = 1;
    expect_oob(32'h0000_2000, "R10 new limit applies");
    cfg_write(1'b1, 32'd64);
    expect_hit(32'h0000_2000, 32'h0004_0010, "R10 R11 new base applies");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_base_msb();
    t_bounds();
    t_error();
    t_stall();
    t_midwalk_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule